// File: doc/BRIEF.md
# Dim Level Slew Limiter with Off Timer

This block sits between an 8-bit requested dim code and the gate pulse timer of a phase-cut dimmer. It does not hand a new request straight to the pulse timer. Instead it keeps its own applied code and moves that code one step toward the request on each pulse of an internal cadence tick. A full sweep from the lowest to the highest code therefore takes a controlled time. The defaults assume a 1 MHz clock: 4170 cycles per step, about 4.17 ms, which gives two steps per 60 Hz half cycle and a 0-to-255 sweep of about one second. When the mains is 50 Hz, an elaboration parameter stretches the step interval by one fifth.

A full-on override input bypasses the ramp and drives the highest code at once. When the override is released, the applied code ramps down from the top toward the request. A request of zero, with no override, starts an off timer. When the timer runs out, the block raises a low-power enable that the bias circuit uses to enter its electronic off state. Any non-zero request, or the override, drops that enable in the same cycle and clears the timer.

The ramp controller has four states:
- HOLD: the applied code equals the target.
- RISE: the target is above the applied code.
- FALL: the target is below the applied code.
- FORCED: the override is active.

The next ramp state is taken each cycle from the override and the comparison of applied code with target, so any state can go to any other in one cycle. The applied code changes only in RISE or FALL on a tick cycle, or when entering FORCED.

The off timer has three states:
- AWAKE goes to COUNTING on a zero request.
- COUNTING goes to ASLEEP when its count expires, or back to AWAKE when the request goes away.
- ASLEEP goes back to AWAKE when the request goes away.

Top module: `dim_slew_limiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `applied_code` is 0 and `low_power_en` is 0.
- R2: When not overridden, `applied_code` changes by exactly one per move, only toward `target_code`. Successive moves are exactly `STEP_BASE` clock cycles apart when `FIFTY_HZ` is 0. The first move after a target change comes within `STEP_BASE` cycles.
- R3: With `FIFTY_HZ` set to 1, successive moves are `STEP_BASE*6/5` cycles apart (integer division).
- R4: Once `applied_code` equals `target_code`, it stays there with no overshoot while the target is unchanged.
- R5: If the target is changed to the other side of the applied code during a ramp, the next move goes in the new direction by one step.
- R6: While `force_full` is 1, `applied_code` is 255 in the same cycle, with no ramp. After release, it ramps down one step per interval from 255.
- R7: A zero request is `target_code` equal to 0 with `force_full` at 0. If a zero request is present at a rising edge E0 and stays, `low_power_en` is 0 up to and including edge E0+`OFF_CYCLES`-1 and is 1 after edge E0+`OFF_CYCLES`.
- R8: A non-zero `target_code` deasserts `low_power_en` in the same cycle and restarts the off timer from zero.
- R9: `force_full` at 1 counts as a non-zero request: `low_power_en` is 0 while it is held.
- R10: A sweep from 0 to 255 completes in at most 255 step intervals and more than 254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| target_code | input | CODE_W | Requested dim code |
| force_full | input | 1 | Full-on override; drives the highest code immediately |
| applied_code | output | CODE_W | Rate-limited dim code for the pulse timer |
| low_power_en | output | 1 | Electronic off-state enable after the off delay |

## Verification
The override and the wake-up are combinational, so the bench drives them on a falling edge and samples the outputs one time unit later, in the same cycle. Ramp moves land on a rising edge. The monitor samples a quarter period after every rising edge and counts the samples between moves: the first move after a new target must arrive within one interval, and each later move exactly one interval after the one before. For the off timer, the bench counts `OFF_CYCLES` rising edges from the first edge that sees the zero request, checks that the enable is still low, then checks that it is high after exactly one more edge.

// File: rtl/dimslew_pkg.sv
package dimslew_pkg;

    typedef enum logic [1:0] {
        ST_HOLD,
        ST_RISE,
        ST_FALL,
        ST_FORCED
    } ramp_state_t;

    typedef enum logic [1:0] {
        OT_AWAKE,
        OT_COUNTING,
        OT_ASLEEP
    } off_state_t;

endpackage

// File: rtl/dimslew_tick.sv
module dimslew_tick #(
    parameter int STEP_CYC = 4170
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = $clog2(STEP_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R2
    tick_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/dimslew_ramp.sv
module dimslew_ramp
    import dimslew_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [CODE_W-1:0] target_code,
    input  logic              force_full,
    output logic [CODE_W-1:0] applied_code
);
    localparam logic [CODE_W-1:0] TOP_CODE = '1;
    localparam logic [CODE_W-1:0] ONE_STEP = {{(CODE_W-1){1'b0}}, 1'b1};

    ramp_state_t       state_q, state_d;
    logic [CODE_W-1:0] step_q, step_d;

    // next-state selection
    always_comb begin
        if (force_full) begin
            state_d = ST_FORCED;
        end else if (step_q < target_code) begin
            state_d = ST_RISE;
        end else if (step_q > target_code) begin
            state_d = ST_FALL;
        end else begin
            state_d = ST_HOLD;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // outputs
    always_comb begin
        step_d       = step_q;
        applied_code = step_q;
        unique case (state_d)
            ST_FORCED: begin
                step_d       = TOP_CODE;
                applied_code = TOP_CODE;
            end
            ST_RISE: if (tick) step_d = step_q + ONE_STEP;
            ST_FALL: if (tick) step_d = step_q - ONE_STEP;
            ST_HOLD: step_d = step_q;
            default: step_d = step_q;
        endcase
    end

    // R2
    move_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_FORCED && step_q != $past(step_q)) |-> $past(tick));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(force_full)) |->
        (step_q == $past(step_q) || step_q == $past(step_q) + ONE_STEP ||
         step_q == $past(step_q) - ONE_STEP));

    // R4
    rise_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(force_full) && $past(step_q) <= $past(target_code)) |->
        (step_q <= $past(target_code)));

    // R4
    fall_no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(force_full) && $past(step_q) >= $past(target_code)) |->
        (step_q >= $past(target_code)));

endmodule

// File: rtl/dimslew_offtimer.sv
module dimslew_offtimer
    import dimslew_pkg::*;
#(
    parameter int OFF_CYC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic zero_req,
    output logic low_power_en
);
    localparam int OFF_W = $clog2(OFF_CYC);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(OFF_CYC - 1);

    off_state_t       st_q, st_d;
    logic [OFF_W-1:0] cnt_q, cnt_d;

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OT_AWAKE:    if (zero_req) st_d = OT_COUNTING;
            OT_COUNTING: begin
                if (!zero_req)         st_d = OT_AWAKE;
                else if (cnt_q == LAST) st_d = OT_ASLEEP;
            end
            OT_ASLEEP:   if (!zero_req) st_d = OT_AWAKE;
            default:     st_d = OT_AWAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= OT_AWAKE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cnt_d        = '0;
        low_power_en = 1'b0;
        unique case (st_q)
            OT_COUNTING: if (zero_req && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
            OT_ASLEEP:   low_power_en = zero_req;
            OT_AWAKE:    cnt_d = '0;
            default:     cnt_d = '0;
        endcase
    end

    // R7
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q == OT_ASLEEP) |->
        ($past(st_q) == OT_COUNTING && $past(cnt_q) == LAST));

    // R7
    lp_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        low_power_en |-> $past(zero_req));

    // R8
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != OT_AWAKE && !zero_req) |=> (st_q == OT_AWAKE && cnt_q == '0));

endmodule

// File: rtl/dim_slew_limiter.sv
module dim_slew_limiter #(
    parameter int CODE_W     = 8,
    parameter int STEP_BASE  = 4170,
    parameter int OFF_CYCLES = 100000,
    parameter bit FIFTY_HZ   = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] target_code,
    input  logic              force_full,
    output logic [CODE_W-1:0] applied_code,
    output logic              low_power_en
);
    localparam int STEP_CYC = FIFTY_HZ ? (STEP_BASE * 6) / 5 : STEP_BASE;

    logic tick;
    logic zero_req;

    assign zero_req = (target_code == '0) && !force_full;

    dimslew_tick #(.STEP_CYC(STEP_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dimslew_ramp #(.CODE_W(CODE_W)) u_ramp (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .target_code  (target_code),
        .force_full   (force_full),
        .applied_code (applied_code)
    );

    dimslew_offtimer #(.OFF_CYC(OFF_CYCLES)) u_off (
        .clk          (clk),
        .rst          (rst),
        .zero_req     (zero_req),
        .low_power_en (low_power_en)
    );

    // R9
    force_no_lp_chk: assert property (@(posedge clk) disable iff (rst)
        force_full |-> !low_power_en);

endmodule

// File: tb/dim_slew_limiter_test.sv
module dim_slew_limiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int STEP   = 20;
    localparam int STEP50 = 24;
    localparam int OFF    = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] target = 8'd0;
    logic       force_full = 1'b0;
    logic [7:0] applied, applied50;
    logic       lp, lp50;

    always #(CLK_PERIOD/2) clk = ~clk;

    dim_slew_limiter #(.CODE_W(8), .STEP_BASE(STEP), .OFF_CYCLES(OFF), .FIFTY_HZ(1'b0)) uut (
        .clk(clk), .rst(rst), .target_code(target), .force_full(force_full),
        .applied_code(applied), .low_power_en(lp));

    dim_slew_limiter #(.CODE_W(8), .STEP_BASE(STEP), .OFF_CYCLES(OFF), .FIFTY_HZ(1'b1)) uut_50 (
        .clk(clk), .rst(rst), .target_code(target), .force_full(force_full),
        .applied_code(applied50), .low_power_en(lp50));

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard state
    logic [7:0] exp_q[$];
    bit         mon_en = 1'b0;
    bit         first_move = 1'b0;
    int         gap = 0;
    logic [7:0] last_seen = 8'd0;
    string      cur_req = "R2";
    event       moved;

    // monitor: samples a quarter period after each rising edge
    initial forever begin
        @(posedge clk);
        #(CLK_PERIOD/4);
        if (rst || !mon_en) begin
            last_seen = applied;
            gap = 0;
        end else begin
            gap++;
            if (applied != last_seen) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_req, " unexpected move"}, applied, last_seen);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(applied == e, {cur_req, " step value"}, applied, e);
                    if (first_move) check(gap <= STEP, {cur_req, " first move delay"}, gap, STEP);
                    else            check(gap == STEP, {cur_req, " step interval"}, gap, STEP);
                end
                first_move = 1'b0;
                gap = 0;
                last_seen = applied;
                -> moved;
            end
        end
    end

    // driver: call on a falling edge
    task automatic start_ramp(input logic [7:0] t, input string req);
        int v;
        cur_req = req;
        exp_q.delete();
        v = last_seen;
        while (v != t) begin
            v = (v < t) ? v + 1 : v - 1;
            exp_q.push_back(8'(v));
        end
        target = t;
        first_move = 1'b1;
        gap = 0;
        mon_en = 1'b1;
    endtask

    task automatic wait_settle();
        int n = 0;
        while (exp_q.size() != 0 && n < 300 * STEP) begin
            @(posedge clk);
            n++;
        end
        repeat (3 * STEP) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ramp_to(input logic [7:0] t, input string req);
        @(negedge clk);
        start_ramp(t, req);
        wait_settle();
        check(applied == t, {req, " R4 hold at target"}, applied, t);
        check(exp_q.size() == 0, {req, " all steps seen"}, exp_q.size(), 0);
    endtask

    // R3: spacing of the 50 Hz instance
    task automatic measure50();
        logic [7:0] prev;
        int seen = 0;
        int c = 0;
        int g = 0;
        prev = applied50;
        while (seen < 3 && c < 10 * STEP50) begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            c++;
            g++;
            if (applied50 != prev) begin
                check(applied50 == prev + 8'd1, "R3 50Hz step value", applied50, prev + 1);
                if (seen > 0) check(g == STEP50, "R3 50Hz interval", g, STEP50);
                seen++;
                g = 0;
                prev = applied50;
            end
        end
        check(seen == 3, "R3 50Hz moves seen", seen, 3);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(applied == 8'd0, "R1 applied in reset", applied, 0);
        check(lp == 1'b0, "R1 low power in reset", lp, 0);
        rst = 1'b0;
        #1;
        check(applied == 8'd0, "R1 applied after reset", applied, 0);

        // R7: zero request from reset
        repeat (OFF) @(posedge clk);
        @(negedge clk);
        check(lp == 1'b0, "R7 before expiry", lp, 0);
        @(posedge clk);
        @(negedge clk);
        check(lp == 1'b1, "R7 after expiry", lp, 1);

        // R8 + R2 + R3
        start_ramp(8'd5, "R2 up");
        #1;
        check(lp == 1'b0, "R8 same-cycle wake", lp, 0);
        fork
            measure50();
            wait_settle();
        join
        check(applied == 8'd5, "R2 R4 hold at 5", applied, 5);

        ramp_to(8'd0, "R2 down");
        repeat (OFF + 5) @(posedge clk);
        @(negedge clk);
        check(lp == 1'b1, "R7 asleep after ramp to zero", lp, 1);

        // R6 + R9 override
        mon_en = 1'b0;
        force_full = 1'b1;
        #1;
        check(applied == 8'd255, "R6 immediate full", applied, 255);
        check(lp == 1'b0, "R9 override wakes", lp, 0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(applied == 8'd255, "R6 held full", applied, 255);
        check(lp == 1'b0, "R9 override holds awake", lp, 0);
        force_full = 1'b0;
        start_ramp(8'd250, "R6 release ramp");
        wait_settle();
        check(applied == 8'd250, "R6 R4 hold after release", applied, 250);

        ramp_to(8'd0, "R2 long down");

        // R10 full sweep
        begin
            int t0;
            int el;
            int n = 0;
            @(negedge clk);
            t0 = cyc;
            start_ramp(8'd255, "R10 sweep");
            while (applied != 8'd255 && n < 300 * STEP) begin
                @(posedge clk);
                #(CLK_PERIOD/4);
                n++;
            end
            el = cyc - t0;
            check(el <= 255 * STEP && el > 254 * STEP, "R10 sweep time", el, 255 * STEP);
            wait_settle();
            check(applied == 8'd255, "R10 R4 hold at top", applied, 255);
        end

        // R5 reversal
        @(negedge clk);
        start_ramp(8'd100, "R5 down leg");
        repeat (10) @(moved);
        @(negedge clk);
        check(applied == 8'd245, "R5 point of reversal", applied, 245);
        start_ramp(8'd250, "R5 reversed");
        wait_settle();
        check(applied == 8'd250, "R5 R4 hold after reversal", applied, 250);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule